// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers interrupt lines from on-chip peripherals and from external request pins and presents a single normal interrupt request to a processor. A separate fast interrupt request output is reserved for one dedicated external pin. Each source has its own enable, a 3-bit priority (eight levels) and a trigger mode. Internal sources can be level or edge sensitive. External sources can be high-level, low-level, rising-edge or falling-edge triggered.

The processor takes an interrupt by reading the vector register. That read returns the winning source number and records the winner's priority on a small level stack. It finishes the interrupt by writing the end-of-interrupt register, which returns to the previous service level. Only a source of strictly higher priority than the level currently being serviced can interrupt again, so handlers nest up to the stack depth.

The level stack is a three-state machine:

- ST_EMPTY means no handler is active.
- ST_NESTED means one or more handlers are active and there is room for more.
- ST_FULL means every slot is occupied.

The transitions are:

- An acknowledge moves ST_EMPTY to ST_NESTED, or straight to ST_FULL when the depth is one.
- An acknowledge that fills the last slot moves ST_NESTED to ST_FULL.
- An end-of-interrupt moves ST_NESTED to ST_EMPTY when it removes the last entry.
- An end-of-interrupt moves ST_FULL to ST_NESTED.
- Every other push or pop keeps ST_NESTED.

Register access uses a plain port with address, write data, write strobe, read strobe and combinational read data.

Top module: `aic_top`

## Requirements
- R1: After reset, irq_o and fiq_o are low, every configuration register reads 0 (all sources disabled), and a vector read returns 32'h0000_00FF.
- R2: Source k (k < N_INT+N_EXT, peripheral lines first, then external pins) is configured at address k. Its bits [2:0] hold the priority, bits [4:3] the trigger mode and bit 7 the enable. For peripheral sources bit 3 is forced to 0, so only high-level (00) and rising-edge (10) apply.
- R3: External sources and the fast pin support four trigger modes: 00 high level, 01 low level, 10 rising edge, 11 falling edge.
- R4: An edge-mode source latches a pending flag on its active edge while enabled, and an acknowledging vector read of that source clears the flag. A level-mode source requests for as long as its input is at the active level.
- R5: A source whose enable bit is 0 never causes a request.
- R6: Among requesting sources, the highest priority wins, and a tie goes to the lowest source number.
- R7: irq_o is high only when a winner exists and either the stack is empty or the winner's priority is strictly greater than the top stack entry.
- R8: A read at address 0x18 while irq_o is high returns bit 31 set with the winner's number in bits [7:0], and pushes the winner's priority. While irq_o is low the read returns 32'h0000_00FF and changes nothing.
- R9: A write at address 0x19 pops the stack and restores the previous service level. On an empty stack it has no effect.
- R10: The stack holds STACK_DEPTH entries. While it is full, irq_o stays low and vector reads return 32'h0000_00FF.
- R11: fiq_o depends only on fast_irq_i, which is configured at address 0x10 with the same enable and mode fields. Its edge flag is cleared by a write at address 0x1A. No peripheral or external source ever drives fiq_o.
- R12: A write to a source's configuration register clears that source's pending edge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| periph_irq_i | input | N_INT | On-chip peripheral interrupt lines (sources 0..N_INT-1) |
| ext_irq_i | input | N_EXT | External normal request pins (sources N_INT..) |
| fast_irq_i | input | 1 | External fast request pin |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe (a vector read acknowledges) |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Normal interrupt request, active high |
| fiq_o | output | 1 | Fast interrupt request, active high |

## Verification
The bench builds the block with N_INT=4, N_EXT=2 and STACK_DEPTH=4. The shallow stack lets four nested acknowledges at priorities 0 to 3 fill it. A priority-4 source is then visibly held off by the ST_FULL state rather than by the priority compare, and it wins again after one pop. The two external pins are enough to exercise all four external trigger modes, and with four peripheral lines the priority tie and the mode restriction on internal sources both come into play.

// File: rtl/aic_pkg.sv
`timescale 1ns/100ps
package aic_pkg;
    localparam int PRIO_W = 3;
    localparam int ADDR_W = 5;
    localparam int ID_W   = 8;

    localparam logic [ADDR_W-1:0] ADR_FAST_CFG = 5'h10;
    localparam logic [ADDR_W-1:0] ADR_VECTOR   = 5'h18;
    localparam logic [ADDR_W-1:0] ADR_EOI      = 5'h19;
    localparam logic [ADDR_W-1:0] ADR_FAST_CLR = 5'h1A;
    localparam logic [31:0]       VEC_SPURIOUS = 32'h0000_00FF;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef struct packed {
        logic               en;
        trig_e              mode;
        logic [PRIO_W-1:0]  prio;
    } src_cfg_t;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_NESTED = 2'd1,
        ST_FULL   = 2'd2
    } lvl_state_e;

    function automatic logic [31:0] cfg_to_word(input src_cfg_t c);
        return {24'd0, c.en, 2'b00, c.mode, c.prio};
    endfunction
endpackage

// File: rtl/aic_src_cell.sv
`timescale 1ns/100ps
module aic_src_cell
    import aic_pkg::*;
#(
    parameter bit RESTRICTED = 1'b0
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        raw_i,
    input  logic        cfg_we_i,
    input  logic [31:0] cfg_wdata_i,
    input  logic        ack_i,
    output src_cfg_t    cfg_o,
    output logic        req_o
);
    src_cfg_t cfg_q;
    logic     prev_q;
    logic     pend_q;
    logic     edge_hit;
    logic     level_hit;
    trig_e    wmode;

    // Peripheral sources accept no polarity choice.
    assign wmode = RESTRICTED ? trig_e'({cfg_wdata_i[4], 1'b0})
                              : trig_e'(cfg_wdata_i[4:3]);

    always_comb begin
        edge_hit  = 1'b0;
        level_hit = 1'b0;
        unique case (cfg_q.mode)
            TRIG_HIGH: level_hit = raw_i;
            TRIG_LOW:  level_hit = ~raw_i;
            TRIG_RISE: edge_hit  = raw_i & ~prev_q;
            TRIG_FALL: edge_hit  = ~raw_i & prev_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q  <= '0;
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= raw_i;
            if (cfg_we_i) begin
                cfg_q  <= '{en: cfg_wdata_i[7], mode: wmode, prio: cfg_wdata_i[2:0]};
                pend_q <= 1'b0;
            end else if (edge_hit && cfg_q.en) begin
                pend_q <= 1'b1;
            end else if (ack_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign cfg_o = cfg_q;
    assign req_o = cfg_q.en & (cfg_q.mode[1] ? pend_q : level_hit);
endmodule

// File: rtl/aic_arbiter.sv
`timescale 1ns/100ps
module aic_arbiter
    import aic_pkg::*;
#(
    parameter int N = 6
) (
    input  logic [N-1:0]        req_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    output logic                found_o,
    output logic [ID_W-1:0]     id_o,
    output logic [PRIO_W-1:0]   prio_o
);
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        prio_o  = '0;
        // Strict compare keeps the lowest index on a tie.
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
                found_o = 1'b1;
                id_o    = ID_W'(i);
                prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/aic_level_stack.sv
`timescale 1ns/100ps
module aic_level_stack
    import aic_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic              pop_i,
    output logic              busy_o,
    output logic              full_o,
    output logic [PRIO_W-1:0] top_prio_o,
    output logic [CW-1:0]     depth_o
);
    lvl_state_e        state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [PRIO_W-1:0] slot_q [DEPTH];
    logic              do_push, do_pop;

    assign do_push = push_i && (state_q != ST_FULL);
    assign do_pop  = pop_i  && (state_q != ST_EMPTY);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (push_i) state_d = (DEPTH == 1) ? ST_FULL : ST_NESTED;
            ST_NESTED: begin
                if (push_i && cnt_q == CW'(DEPTH - 1))  state_d = ST_FULL;
                else if (pop_i && cnt_q == CW'(1))      state_d = ST_EMPTY;
            end
            ST_FULL:   if (pop_i) state_d = (DEPTH == 1) ? ST_EMPTY : ST_NESTED;
            default:   state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (do_push)     cnt_q <= cnt_q + 1'b1;
            else if (do_pop) cnt_q <= cnt_q - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                        slot_q[g] <= '0;
            else if (do_push && cnt_q == CW'(g)) slot_q[g] <= push_prio_i;
        end
    end

    always_comb begin
        busy_o     = (state_q != ST_EMPTY);
        full_o     = (state_q == ST_FULL);
        depth_o    = cnt_q;
        top_prio_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CW'(i + 1)) top_prio_o = slot_q[i];
        end
    end
endmodule

// File: rtl/aic_top.sv
`timescale 1ns/100ps
module aic_top
    import aic_pkg::*;
#(
    parameter  int N_INT       = 4,
    parameter  int N_EXT       = 2,
    parameter  int STACK_DEPTH = 8,
    localparam int N_SRC       = N_INT + N_EXT,
    localparam int SDW         = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_INT-1:0]  periph_irq_i,
    input  logic [N_EXT-1:0]  ext_irq_i,
    input  logic              fast_irq_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    input  logic              reg_we_i,
    input  logic              reg_re_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [N_SRC-1:0]        raw_src;
    logic [N_SRC-1:0]        src_req;
    src_cfg_t                cfg [N_SRC];
    src_cfg_t                fast_cfg;
    logic [N_SRC*PRIO_W-1:0] prio_flat;
    logic                    win_found;
    logic [ID_W-1:0]         win_id;
    logic [PRIO_W-1:0]       win_prio;
    logic                    stk_busy, stk_full;
    logic [PRIO_W-1:0]       top_prio;
    logic [SDW-1:0]          stk_depth;
    logic                    ack_fire, eoi_wr;

    assign raw_src  = {ext_irq_i, periph_irq_i};
    assign ack_fire = reg_re_i && (reg_addr_i == ADR_VECTOR) && irq_o;
    assign eoi_wr   = reg_we_i && (reg_addr_i == ADR_EOI);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        aic_src_cell #(.RESTRICTED(g < N_INT)) u_cell (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .raw_i       (raw_src[g]),
            .cfg_we_i    (reg_we_i && reg_addr_i == ADDR_W'(g)),
            .cfg_wdata_i (reg_wdata_i),
            .ack_i       (ack_fire && win_id == ID_W'(g)),
            .cfg_o       (cfg[g]),
            .req_o       (src_req[g])
        );
        assign prio_flat[g*PRIO_W +: PRIO_W] = cfg[g].prio;
    end

    aic_src_cell #(.RESTRICTED(1'b0)) u_fast (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .raw_i       (fast_irq_i),
        .cfg_we_i    (reg_we_i && reg_addr_i == ADR_FAST_CFG),
        .cfg_wdata_i (reg_wdata_i),
        .ack_i       (reg_we_i && reg_addr_i == ADR_FAST_CLR),
        .cfg_o       (fast_cfg),
        .req_o       (fiq_o)
    );

    aic_arbiter #(.N(N_SRC)) u_arb (
        .req_i   (src_req),
        .prio_i  (prio_flat),
        .found_o (win_found),
        .id_o    (win_id),
        .prio_o  (win_prio)
    );

    aic_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (ack_fire),
        .push_prio_i (win_prio),
        .pop_i       (eoi_wr),
        .busy_o      (stk_busy),
        .full_o      (stk_full),
        .top_prio_o  (top_prio),
        .depth_o     (stk_depth)
    );

    assign irq_o = win_found && !stk_full && (!stk_busy || win_prio > top_prio);

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADR_VECTOR) begin
            reg_rdata_o = irq_o ? {1'b1, 23'd0, win_id} : VEC_SPURIOUS;
        end else if (reg_addr_i == ADR_FAST_CFG) begin
            reg_rdata_o = cfg_to_word(fast_cfg);
        end else begin
            for (int i = 0; i < N_SRC; i++) begin
                if (reg_addr_i == ADDR_W'(i)) reg_rdata_o = cfg_to_word(cfg[i]);
            end
        end
    end
endmodule

// File: rtl/aic_checker.sv
`timescale 1ns/100ps
module aic_checker
    import aic_pkg::*;
#(
    parameter  int N_SRC = 6,
    parameter  int DEPTH = 8,
    localparam int DW    = $clog2(DEPTH + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              irq_o,
    input logic [N_SRC-1:0]  src_req,
    input logic              reg_re_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [DW-1:0]     depth,
    input logic              full
);
    AST_FULL_BLOCKS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full |-> !irq_o); // R10

    AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        depth <= DW'(DEPTH)); // R10

    AST_ACK_PUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_re_i && reg_addr_i == ADR_VECTOR && irq_o) |=> depth == DW'($past(depth) + 1'b1)); // R8

    AST_EOI_POPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == ADR_EOI && depth != '0) |=> depth == DW'($past(depth) - 1'b1)); // R9

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (|src_req)); // R5
endmodule

bind aic_top aic_checker #(.N_SRC(N_SRC), .DEPTH(STACK_DEPTH)) u_aic_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_o      (irq_o),
    .src_req    (src_req),
    .reg_re_i   (reg_re_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .depth      (stk_depth),
    .full       (stk_full)
);

// File: tb/test_aic_top.sv
`timescale 1ns/100ps
module test_aic_top;
    import aic_pkg::*;

    localparam int NI = 4;
    localparam int NE = 2;
    localparam int SD = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NI-1:0]     periph = '0;
    logic [NE-1:0]     ext = '0;
    logic              fast = 1'b0;
    logic [ADDR_W-1:0] addr = 5'h1F;
    logic [31:0]       wdata = '0;
    logic              we = 1'b0;
    logic              re = 1'b0;
    logic [31:0]       rdata;
    logic              irq, fiq;

    aic_top #(.N_INT(NI), .N_EXT(NE), .STACK_DEPTH(SD)) i_aic_top (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .periph_irq_i (periph),
        .ext_irq_i    (ext),
        .fast_irq_i   (fast),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_we_i     (we),
        .reg_re_i     (re),
        .reg_rdata_o  (rdata),
        .irq_o        (irq),
        .fiq_o        (fiq)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          at;
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    localparam logic [31:0] SPUR = 32'h0000_00FF;
    localparam logic [31:0] VOK  = 32'h8000_0000;

    // Monitor: compares the design's outputs with queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0 && sb_q[0].at == cyc) begin
                item_t       it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = rdata;
                    1:       act = {31'd0, irq};
                    default: act = {31'd0, fiq};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_exp(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.at = cyc; it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drive(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                         input logic w, input logic r);
        @(negedge clk);
        addr = a; wdata = d; we = w; re = r;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        drive(a, d, 1'b1, 1'b0);
    endtask

    task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        drive(a, '0, 1'b0, 1'b1);
        push_exp(0, exp, tag);
    endtask

    task automatic chk_out(input logic ei, input logic ef, input string tag);
        drive(5'h1F, '0, 1'b0, 1'b0);
        push_exp(1, {31'd0, ei}, tag);
        push_exp(2, {31'd0, ef}, tag);
    endtask

    task automatic set_p(input int i, input logic v);
        drive(5'h1F, '0, 1'b0, 1'b0);
        periph[i] = v;
    endtask

    task automatic set_e(input int i, input logic v);
        drive(5'h1F, '0, 1'b0, 1'b0);
        ext[i] = v;
    endtask

    task automatic set_f(input logic v);
        drive(5'h1F, '0, 1'b0, 1'b0);
        fast = v;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        chk_out(1'b0, 1'b0, "R1 outputs after reset");
        rd_exp(ADR_VECTOR, SPUR, "R1 vector empty");
        rd_exp(5'h00, 32'h0, "R1 config cleared");

        wr(5'h01, 32'h83);
        set_p(1, 1'b1);
        chk_out(1'b1, 1'b0, "R4 level source requests");
        rd_exp(5'h01, 32'h83, "R2 config readback");
        wr(5'h02, 32'h8A);
        rd_exp(5'h02, 32'h82, "R2 internal low-level forced to high");

        wr(5'h00, 32'h83);
        set_p(0, 1'b1);
        rd_exp(ADR_VECTOR, VOK | 32'd0, "R6 tie to lowest number");
        chk_out(1'b0, 1'b0, "R7 equal priority held off");

        wr(5'h04, 32'h95);
        set_e(0, 1'b1);
        chk_out(1'b1, 1'b0, "R4 rising edge latched");
        rd_exp(ADR_VECTOR, VOK | 32'd4, "R8 vector of preempting source");
        chk_out(1'b0, 1'b0, "R4 pending cleared by acknowledge");
        wr(ADR_EOI, 32'h0);
        chk_out(1'b0, 1'b0, "R9 level restored to 3");
        wr(ADR_EOI, 32'h0);
        chk_out(1'b1, 1'b0, "R9 stack empty again");
        rd_exp(ADR_VECTOR, VOK | 32'd0, "R6 level source again");

        wr(5'h00, 32'h03);
        wr(5'h01, 32'h03);
        wr(ADR_EOI, 32'h0);
        chk_out(1'b0, 1'b0, "R5 masked sources silent");
        rd_exp(ADR_VECTOR, SPUR, "R5 R8 spurious vector");

        wr(5'h05, 32'h9E);
        set_e(1, 1'b1);
        chk_out(1'b0, 1'b0, "R3 falling mode ignores rise");
        set_e(1, 1'b0);
        chk_out(1'b1, 1'b0, "R3 falling edge latched");
        rd_exp(ADR_VECTOR, VOK | 32'd5, "R3 falling source vector");

        wr(5'h04, 32'h8F);
        chk_out(1'b0, 1'b0, "R3 low level inactive while high");
        set_e(0, 1'b0);
        chk_out(1'b1, 1'b0, "R3 low level active");
        rd_exp(ADR_VECTOR, VOK | 32'd4, "R8 nested vector");
        wr(ADR_EOI, 32'h0);
        wr(ADR_EOI, 32'h0);
        chk_out(1'b1, 1'b0, "R4 level persists after service");
        set_e(0, 1'b1);
        chk_out(1'b0, 1'b0, "R3 low level released");

        wr(5'h05, 32'h91);
        set_e(1, 1'b1);
        chk_out(1'b1, 1'b0, "R12 edge pending before rewrite");
        wr(5'h05, 32'h91);
        chk_out(1'b0, 1'b0, "R12 rewrite clears pending");

        set_p(2, 1'b1);
        chk_out(1'b1, 1'b0, "R4 level on source 2");
        wr(ADR_EOI, 32'h0);
        chk_out(1'b1, 1'b0, "R9 end-of-interrupt on empty stack ignored");

        wr(5'h02, 32'h02);
        chk_out(1'b0, 1'b0, "R5 disabled source silent");
        wr(5'h00, 32'h80);
        rd_exp(ADR_VECTOR, VOK | 32'd0, "R8 push level 0");
        wr(5'h01, 32'h81);
        rd_exp(ADR_VECTOR, VOK | 32'd1, "R7 preempt level 1");
        wr(5'h02, 32'h82);
        rd_exp(ADR_VECTOR, VOK | 32'd2, "R7 preempt level 2");
        set_p(3, 1'b1);
        wr(5'h03, 32'h83);
        rd_exp(ADR_VECTOR, VOK | 32'd3, "R7 preempt level 3");
        wr(5'h04, 32'h84);
        chk_out(1'b0, 1'b0, "R10 full stack blocks request");
        rd_exp(ADR_VECTOR, SPUR, "R10 full stack vector spurious");
        wr(ADR_EOI, 32'h0);
        chk_out(1'b1, 1'b0, "R10 request after pop");
        rd_exp(ADR_VECTOR, VOK | 32'd4, "R6 highest priority wins");
        for (int k = 0; k < SD; k++) wr(ADR_EOI, 32'h0);
        chk_out(1'b1, 1'b0, "R11 sources never drive fast line");

        wr(ADR_FAST_CFG, 32'h90);
        set_f(1'b1);
        chk_out(1'b1, 1'b1, "R11 fast rising edge");
        wr(ADR_FAST_CLR, 32'h0);
        chk_out(1'b1, 1'b0, "R11 fast clear");
        wr(ADR_FAST_CFG, 32'h88);
        chk_out(1'b1, 1'b0, "R11 fast low level inactive");
        rd_exp(ADR_FAST_CFG, 32'h88, "R11 fast config readback");
        set_f(1'b0);
        chk_out(1'b1, 1'b1, "R11 fast low level active");

        drive(5'h1F, '0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule